// File: doc/BRIEF.md
# Clocked Serial Byte Receiver

This block takes bytes from an instrument over a clocked serial link. The system clock runs much faster than the link. A one-cycle enable marks each link-clock period, and the serial line is sampled only in those cycles. A frame is one start bit (0), eight data bits sent most significant bit first, and one trailing parity bit. The parity bit must be 1 when the data holds an even number of ones, and 0 when it holds an odd number. Each received byte is reported with a one-cycle valid strobe. A byte with bad parity is still delivered, with an error flag raised alongside the strobe.

Two timing rules are watched beside the data path. After each parity bit, the line must stay idle for a minimum number of link periods before the next start bit; a start that comes too early pulses a gap flag. A response timer is armed by a pulse from the host's command sender. If no start bit appears within a fixed number of link periods, the timer pulses a timeout flag. The first start bit stops the timer, and only the next command-done pulse arms it again.

The frame logic is a state machine with three states:

- `ST_IDLE` moves to `ST_DATA` when a 0 is sampled on a link tick.
- `ST_DATA` moves to `ST_PARITY` after the eighth data tick.
- `ST_PARITY` returns to `ST_IDLE` on the parity tick.

The timer has two states:

- `TM_OFF` moves to `TM_WAIT` on a command-done pulse.
- `TM_WAIT` returns to `TM_OFF` on a start bit, or when the window expires.

Top module: `serial_byte_rx`

## Requirements
- R1: The line is sampled only in cycles where `bit_en` is 1. A 0 sampled in `ST_IDLE` is a start bit. A low level between ticks, while no tick is present, starts nothing.
- R2: The eight ticks after the start bit carry the data, most significant bit first. The assembled byte appears on `rx_byte`.
- R3: The expected parity bit is 1 for an even ones-count and 0 for an odd ones-count. `parity_err` is 1 when the sampled parity bit differs from the expected value, and 0 otherwise.
- R4: A byte that fails parity is still delivered on `rx_byte` with `rx_valid`. `parity_err` is only ever 1 in the same cycle as `rx_valid`.
- R5: `rx_valid` is a single-cycle pulse. It comes one system clock after the parity tick.
- R6: Suppose a start bit is sampled after fewer than MIN_GAP idle ticks since the previous parity tick (default 2). Then `gap_err` pulses for one cycle, one clock after that start tick. With MIN_GAP or more idle ticks, there is no pulse. The byte is received either way.
- R7: A `cmd_done` pulse arms the timer. If TIMEOUT_TICKS ticks (default 20) pass with no start bit, `timeout_err` pulses for one cycle, one clock after the last of those ticks, and the timer disarms.
- R8: A start bit on or before the TIMEOUT_TICKS-th tick after arming disarms the timer with no timeout. Without a fresh `cmd_done`, no later idle period raises `timeout_err`.
- R9: After reset, all outputs are 0, the frame machine is idle and the timer is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-cycle enable per link-clock period |
| rx_line | input | 1 | Serial data line, idle high |
| cmd_done | input | 1 | Pulse when the host has sent the last command bit |
| rx_byte | output | DATA_W | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a new byte |
| parity_err | output | 1 | Parity mismatch, valid with `rx_valid` |
| timeout_err | output | 1 | One-cycle pulse: no response within the window |
| gap_err | output | 1 | One-cycle pulse: start bit arrived too soon |

## Verification
The bench builds the block with its default parameters: eight data bits, a two-tick minimum gap and a twenty-tick response window. A link tick comes every fourth system clock. Because the window is short, the bench can step to the exact tick where the timeout fires. This lets it check both the 19th tick (no pulse) and the 20th (pulse), and a start bit that lands on the 20th tick itself. The two-tick gap lets it contrast one idle tick against two between back-to-back frames.

// File: rtl/rx_pkg.sv
package rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DATA   = 2'd1,
        ST_PARITY = 2'd2
    } rx_state_e;

    typedef enum logic {
        TM_OFF  = 1'b0,
        TM_WAIT = 1'b1
    } tm_state_e;

endpackage

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line,
    output logic [DATA_W-1:0] byte_q,
    output logic              valid_q,
    output logic              perr_q,
    output logic              start_det,
    output logic              frame_end
);

    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    rx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [DATA_W-1:0] shift_q;

    // next-state and event decode
    always_comb begin
        state_d   = state_q;
        start_det = 1'b0;
        frame_end = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (tick && !line) begin
                    state_d   = ST_DATA;
                    start_det = 1'b1;
                end
            end
            ST_DATA: begin
                if (tick && bit_cnt_q == LAST_BIT) begin
                    state_d = ST_PARITY;
                end
            end
            ST_PARITY: begin
                if (tick) begin
                    state_d   = ST_IDLE;
                    frame_end = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // shift path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            shift_q   <= '0;
        end else if (state_q == ST_IDLE) begin
            bit_cnt_q <= '0;
        end else if (state_q == ST_DATA && tick) begin
            shift_q   <= {shift_q[DATA_W-2:0], line};
            bit_cnt_q <= bit_cnt_q + 1'b1;
        end
    end

    // outputs: expected parity is the inverse of the data XOR
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q  <= '0;
            valid_q <= 1'b0;
            perr_q  <= 1'b0;
        end else begin
            valid_q <= frame_end;
            perr_q  <= 1'b0;
            if (frame_end) begin
                byte_q <= shift_q;
                perr_q <= (line == ^shift_q);
            end
        end
    end

endmodule

// File: rtl/rx_gap_monitor.sv
module rx_gap_monitor #(
    parameter int MIN_GAP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start_det,
    input  logic frame_end,
    output logic gap_err
);

    localparam int GW = $clog2(MIN_GAP + 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(MIN_GAP - 1);

    logic          watch_q;
    logic [GW-1:0] idle_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            watch_q    <= 1'b0;
            idle_cnt_q <= '0;
            gap_err    <= 1'b0;
        end else begin
            gap_err <= 1'b0;
            if (frame_end) begin
                watch_q    <= 1'b1;
                idle_cnt_q <= '0;
            end else if (start_det) begin
                gap_err <= watch_q;
                watch_q <= 1'b0;
            end else if (tick && watch_q) begin
                if (idle_cnt_q == GAP_LAST) begin
                    watch_q <= 1'b0;
                end else begin
                    idle_cnt_q <= idle_cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/rx_resp_timer.sv
module rx_resp_timer
    import rx_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start_det,
    input  logic cmd_done,
    output logic timeout_err
);

    localparam int TW = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT_TICKS - 1);

    tm_state_e     tm_q, tm_d;
    logic [TW-1:0] cnt_q;
    logic          expire;

    always_comb begin
        tm_d   = tm_q;
        expire = 1'b0;
        unique case (tm_q)
            TM_OFF: begin
                if (cmd_done) tm_d = TM_WAIT;
            end
            TM_WAIT: begin
                if (cmd_done) begin
                    tm_d = TM_WAIT;
                end else if (start_det) begin
                    tm_d = TM_OFF;
                end else if (tick && cnt_q == T_LAST) begin
                    tm_d   = TM_OFF;
                    expire = 1'b1;
                end
            end
            default: tm_d = TM_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tm_q <= TM_OFF;
        end else begin
            tm_q <= tm_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            timeout_err <= 1'b0;
        end else begin
            timeout_err <= expire;
            if (cmd_done) begin
                cnt_q <= '0;
            end else if (tm_q == TM_WAIT && tick && !start_det) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/serial_byte_rx.sv
module serial_byte_rx #(
    parameter int DATA_W        = 8,
    parameter int MIN_GAP       = 2,
    parameter int TIMEOUT_TICKS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              rx_line,
    input  logic              cmd_done,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              parity_err,
    output logic              timeout_err,
    output logic              gap_err
);

    logic start_det;
    logic frame_end;

    rx_frame_fsm #(.DATA_W(DATA_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (bit_en),
        .line      (rx_line),
        .byte_q    (rx_byte),
        .valid_q   (rx_valid),
        .perr_q    (parity_err),
        .start_det (start_det),
        .frame_end (frame_end)
    );

    rx_gap_monitor #(.MIN_GAP(MIN_GAP)) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (bit_en),
        .start_det (start_det),
        .frame_end (frame_end),
        .gap_err   (gap_err)
    );

    rx_resp_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (bit_en),
        .start_det   (start_det),
        .cmd_done    (cmd_done),
        .timeout_err (timeout_err)
    );

endmodule

// File: rtl/serial_byte_rx_chk.sv
module serial_byte_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic rx_line,
    input logic cmd_done,
    input logic rx_valid,
    input logic parity_err,
    input logic timeout_err,
    input logic gap_err
);

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R5
    valid_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(bit_en));

    // R4
    perr_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        parity_err |-> rx_valid);

    // R6
    gap_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gap_err |-> ($past(bit_en) && !$past(rx_line)));

    // R7
    timeout_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |=> !timeout_err);

    // R7
    timeout_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> ($past(bit_en) && !$past(cmd_done)));

endmodule

bind serial_byte_rx serial_byte_rx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en      (bit_en),
    .rx_line     (rx_line),
    .cmd_done    (cmd_done),
    .rx_valid    (rx_valid),
    .parity_err  (parity_err),
    .timeout_err (timeout_err),
    .gap_err     (gap_err)
);

// File: tb/serial_byte_rx_tb.sv
module serial_byte_rx_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       rx_line = 1'b1;
    logic       cmd_done = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_valid, parity_err, timeout_err, gap_err;

    int checks = 0;
    int fails  = 0;
    int n_valid = 0, n_timeout = 0, n_gap = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [7:0] s_byte;
    logic       s_valid, s_perr, s_tmo, s_gap, st_gap;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_byte_rx #(.DATA_W(8), .MIN_GAP(2), .TIMEOUT_TICKS(20)) u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_line(rx_line),
        .cmd_done(cmd_done), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .parity_err(parity_err), .timeout_err(timeout_err), .gap_err(gap_err)
    );

    always @(negedge clk) begin
        if (rx_valid)    n_valid++;
        if (timeout_err) n_timeout++;
        if (gap_err)     n_gap++;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        rx_line = b;
        bit_en  = 1'b1;
        @(negedge clk);
        bit_en  = 1'b0;
        s_byte  = rx_byte;
        s_valid = rx_valid;
        s_perr  = parity_err;
        s_tmo   = timeout_err;
        s_gap   = gap_err;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic idle_ticks(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
    endtask

    task automatic send_byte(input logic [7:0] d, input logic good_par);
        send_bit(1'b0);
        st_gap = s_gap;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        send_bit(good_par ? ~^d : ^d);
    endtask

    task automatic pulse_cmd_done();
        @(negedge clk);
        cmd_done = 1'b1;
        @(negedge clk);
        cmd_done = 1'b0;
    endtask

    task automatic t_reset();
        // R9
        check("R9 rx_valid", rx_valid, 0);
        check("R9 rx_byte", rx_byte, 0);
        check("R9 flags", {parity_err, timeout_err, gap_err}, 0);
    endtask

    task automatic t_good_bytes();
        int v0;
        v0 = n_valid;
        send_byte(8'hA5, 1'b1);
        check("R2 msb first byte", s_byte, 8'hA5);
        check("R5 valid after parity tick", s_valid, 1);
        check("R3 even ones parity ok", s_perr, 0);
        check("R5 single pulse", n_valid - v0, 1);
        idle_ticks(3);
        send_byte(8'h01, 1'b1);
        check("R2 byte 01", s_byte, 8'h01);
        check("R3 odd ones parity ok", s_perr, 0);
        idle_ticks(3);
        send_byte(8'hC4, 1'b1);
        check("R2 byte C4", s_byte, 8'hC4);
        check("R3 odd ones C4 parity ok", s_perr, 0);
        idle_ticks(3);
    endtask

    task automatic t_bad_parity();
        send_byte(8'h3C, 1'b0);
        check("R4 errored byte delivered", s_valid, 1);
        check("R4 errored byte value", s_byte, 8'h3C);
        check("R3 parity error flagged", s_perr, 1);
        idle_ticks(3);
        send_byte(8'h80, 1'b0);
        check("R3 parity error odd", s_perr, 1);
        idle_ticks(3);
    endtask

    task automatic t_glitch();
        int v0;
        v0 = n_valid;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            rx_line = 1'b0;
            @(negedge clk);
            rx_line = 1'b1;
            send_bit(1'b1);
        end
        check("R1 low between ticks ignored", n_valid - v0, 0);
    endtask

    task automatic t_gap();
        int g0;
        send_byte(8'h11, 1'b1);
        g0 = n_gap;
        idle_ticks(2);
        send_byte(8'h22, 1'b1);
        check("R6 two idle ticks no gap error", n_gap - g0, 0);
        idle_ticks(1);
        send_byte(8'h5A, 1'b1);
        check("R6 one idle tick gap error", st_gap, 1);
        check("R6 gap pulse count", n_gap - g0, 1);
        check("R6 byte still received", s_byte, 8'h5A);
        send_byte(8'h6B, 1'b1);
        check("R6 zero idle ticks gap error", st_gap, 1);
        idle_ticks(3);
    endtask

    task automatic t_timeout();
        int t0;
        t0 = n_timeout;
        pulse_cmd_done();
        idle_ticks(19);
        check("R7 no timeout at tick 19", n_timeout - t0, 0);
        send_bit(1'b1);
        check("R7 timeout at tick 20", s_tmo, 1);
        check("R7 single timeout pulse", n_timeout - t0, 1);
        idle_ticks(25);
        check("R8 disarmed after expiry", n_timeout - t0, 1);
    endtask

    task automatic t_late_start();
        int t0;
        t0 = n_timeout;
        pulse_cmd_done();
        idle_ticks(19);
        send_byte(8'hE7, 1'b1);
        check("R8 start on tick 20 no timeout", n_timeout - t0, 0);
        check("R8 byte received", s_byte, 8'hE7);
        idle_ticks(30);
        check("R8 no re-arm without cmd_done", n_timeout - t0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_good_bytes();
        t_bad_parity();
        t_glitch();
        t_gap();
        t_timeout();
        t_late_start();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, WATCHDOG);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule